// File: doc/BRIEF.md
# Quasi-Resonant Gate Timing Controller

This block decides, on every cycle, whether the gate of a flyback power switch is driven high or low. It runs on a digital clock and takes comparator decisions as single-bit inputs. One input pulses at each zero crossing of the ringing drain voltage. One flag reports whether that ringing sits below a level threshold. Three trips report the feedback regulation point, the cycle-by-cycle current limit and a shorted winding. A reference valley number arrives from an external up/down counter.

An on period ends when a trip fires after the blanking window, or when the maximum on time runs out. An off period lasts at least a ringing-suppression window. The window is long or short, and the choice is taken from the ringing flag at the moment the gate turns off. Once that window has passed, the gate turns on as soon as the number of counted zero crossings reaches the reference valley number. A maximum off time forces the gate on if enough crossings never arrive. A shorted-winding trip that persists through its filter window latches the gate off until reset. All timings are parameters in clock cycles.

Top module: `qr_gate_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `gate_o` and `fault_o` are 0. The first off period after reset uses the long suppression window `RS_LONG`, whatever `ring_low_i` shows.
- R2: Both trips are ignored during the first `LEB` cycles of an on period, so the gate stays high for at least `LEB` cycles unless a fault latches.
- R3: If `fb_trip_i` is high in on cycle k (counting from 1) with k > `LEB`, the gate is high for exactly k cycles and low from the next cycle.
- R4: If `ilim_trip_i` is high in on cycle k with k > `LEB`, `gate_o` drops in that same cycle without waiting for a clock edge, so the gate is high for k-1 cycles.
- R5: An on period with no effective trip lasts exactly `ON_MAX` cycles.
- R6: The gate cannot turn on until the off period has lasted `RS_LONG` cycles if `ring_low_i` was 1 at the clock edge that turned the gate off, or `RS_SHORT` cycles if it was 0. Later changes of `ring_low_i` within that off period have no effect.
- R7: Rising edges of `zc_i` seen while the gate is off are counted after a two-flop synchronizer. If the v-th edge is high during off cycle c, the gate turns on after off cycle max(c+3, suppression length), provided `valley_ref_i` = v.
- R8: The zero-crossing count clears when the gate turns on and stays clear through the on period. Edges that arrive while the gate is high never count toward the next off period.
- R9: If the turn-on condition is never met, the off period lasts exactly `OFF_MAX` cycles and the gate is then forced on.
- R10: A run of `SSW` consecutive cycles with `short_trip_i` high sets `fault_o` and forces `gate_o` low from the next cycle. Shorter runs, including runs broken by a single low cycle, have no effect.
- R11: Once set, `fault_o` stays high and `gate_o` stays low, whatever the inputs, until `rst` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_i | input | 1 | Zero-crossing comparator output, asynchronous |
| ring_low_i | input | 1 | 1 when the ringing level is below its threshold |
| fb_trip_i | input | 1 | Feedback regulation trip |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit trip |
| short_trip_i | input | 1 | Shorted-winding current trip |
| valley_ref_i | input | VALLEY_W | Reference valley count for turn-on |
| gate_o | output | 1 | Gate drive |
| fault_o | output | 1 | Latched shorted-winding fault |

## Verification
The bench sweeps the cycle in which each trip first appears across the whole on period. A design with an off-by-one in blanking, or one that registers the current-limit trip instead of cutting the gate at once, shows a pulse one cycle too long. It sweeps the reference valley number with zero-crossing pulses at known cycles, so synchronizer latency errors and a counter that keeps edges from the on period or from the previous off period show up as wrong off lengths or as a missed forced turn-on. It also flips the ringing flag just after turn-off to catch a window length that follows the live input. It drives shorted-winding runs one cycle short, and runs broken by one low cycle, to catch a filter that fires early or does not restart.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_ON    = 2'd1,
        PH_FAULT = 2'd2
    } phase_e;

    typedef struct packed {
        logic fb;
        logic ilim;
        logic shrt;
    } trip_s;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qr_zc_counter.sv
module qr_zc_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_async,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    logic [2:0] sync_q;
    logic       rise;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], zc_async};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst || clear)            count <= '0;
        else if (rise && count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/qr_phase_timer.sv
module qr_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [TW-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (rst || restart)     elapsed <= '0;
        else if (elapsed != '1) elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/qr_short_filter.sv
module qr_short_filter #(
    parameter int SSW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    output logic fire
);
    localparam int RW = $clog2(SSW + 1);
    localparam logic [RW-1:0] LAST = RW'(SSW - 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !trip)     run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
    end

    assign fire = trip && (run_q == LAST);
endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
    import qr_gate_pkg::*;
#(
    parameter int LEB      = 8,
    parameter int ON_MAX   = 200,
    parameter int RS_SHORT = 40,
    parameter int RS_LONG  = 80,
    parameter int OFF_MAX  = 2500,
    parameter int SSW      = 16,
    parameter int VALLEY_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                zc_i,
    input  logic                ring_low_i,
    input  logic                fb_trip_i,
    input  logic                ilim_trip_i,
    input  logic                short_trip_i,
    input  logic [VALLEY_W-1:0] valley_ref_i,
    output logic                gate_o,
    output logic                fault_o
);
    localparam int TW = $clog2(max2(ON_MAX, OFF_MAX) + 1);
    localparam logic [TW-1:0] LEB_T    = TW'(LEB);
    localparam logic [TW-1:0] ONM_T    = TW'(ON_MAX - 1);
    localparam logic [TW-1:0] OFFM_T   = TW'(OFF_MAX - 1);
    localparam logic [TW-1:0] RSS_T    = TW'(RS_SHORT - 1);
    localparam logic [TW-1:0] RSL_T    = TW'(RS_LONG - 1);

    phase_e              phase_q, phase_d;
    trip_s               trips;
    logic [TW-1:0]       elapsed;
    logic [VALLEY_W-1:0] zc_count;
    logic                rs_long_q;
    logic                short_fire;
    logic                blank_done, supp_done, valley_ok;

    assign trips = '{fb: fb_trip_i, ilim: ilim_trip_i, shrt: short_trip_i};

    qr_zc_counter #(.CNT_W(VALLEY_W)) u_zc (
        .clk      (clk),
        .rst      (rst),
        .zc_async (zc_i),
        .clear    (phase_q != PH_OFF),
        .count    (zc_count)
    );

    qr_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (phase_d != phase_q),
        .elapsed (elapsed)
    );

    qr_short_filter #(.SSW(SSW)) u_short (
        .clk  (clk),
        .rst  (rst),
        .trip (trips.shrt),
        .fire (short_fire)
    );

    assign blank_done = elapsed >= LEB_T;
    assign supp_done  = elapsed >= (rs_long_q ? RSL_T : RSS_T);
    assign valley_ok  = zc_count >= valley_ref_i;

    always_comb begin
        phase_d = phase_q;
        if (short_fire) begin
            phase_d = PH_FAULT;
        end else begin
            case (phase_q)
                PH_OFF: if (elapsed == OFFM_T || (supp_done && valley_ok)) phase_d = PH_ON;
                PH_ON:  if (elapsed == ONM_T || (blank_done && (trips.fb || trips.ilim)))
                            phase_d = PH_OFF;
                default: phase_d = PH_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_OFF;
            rs_long_q <= 1'b1;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_ON && phase_d == PH_OFF) rs_long_q <= ring_low_i;
        end
    end

    assign gate_o  = (phase_q == PH_ON) && !(blank_done && trips.ilim);
    assign fault_o = (phase_q == PH_FAULT);
endmodule

// File: rtl/qr_gate_ctrl_chk.sv
module qr_gate_ctrl_chk #(
    parameter int LEB      = 8,
    parameter int ON_MAX   = 200,
    parameter int RS_SHORT = 40,
    parameter int OFF_MAX  = 2500
) (
    input logic clk,
    input logic rst,
    input logic gate_o,
    input logic fault_o
);
    localparam int RW = $clog2(ON_MAX + OFF_MAX + 2) + 1;
    localparam logic [RW-1:0] TOP = '1;

    logic [RW-1:0] on_run, off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_run  <= '0;
            off_run <= '0;
        end else begin
            on_run  <= gate_o ? ((on_run != TOP) ? on_run + 1'b1 : on_run) : '0;
            off_run <= (gate_o || fault_o) ? '0 : ((off_run != TOP) ? off_run + 1'b1 : off_run);
        end
    end

    p_min_on_r2: assert property (@(posedge clk) disable iff (rst)
        (!gate_o && !fault_o && on_run != '0) |-> (on_run >= RW'(LEB)));

    p_max_on_r5: assert property (@(posedge clk) disable iff (rst)
        on_run <= RW'(ON_MAX));

    p_supp_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_o && off_run != '0) |-> (off_run >= RW'(RS_SHORT)));

    p_max_off_r9: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> (off_run <= RW'(OFF_MAX + 1)));

    p_fault_gate_r10: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !gate_o);

    p_fault_hold_r11: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o);
endmodule

bind qr_gate_ctrl qr_gate_ctrl_chk #(
    .LEB      (LEB),
    .ON_MAX   (ON_MAX),
    .RS_SHORT (RS_SHORT),
    .OFF_MAX  (OFF_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .gate_o  (gate_o),
    .fault_o (fault_o)
);

// File: tb/qr_gate_ctrl_tb.sv
module qr_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEB = 3, ON_MAX = 20, RS_SHORT = 4, RS_LONG = 8, OFF_MAX = 30, SSW = 3, VW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic zc = 0, ring_low = 0, fb = 0, ilim = 0, shrt = 0;
    logic [VW-1:0] valley = '0;
    logic gate_o, fault_o;

    int checks = 0, errors = 0;
    int cur_hi = 0, cur_lo = 0, last_hi = 0, last_lo = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qr_gate_ctrl #(.LEB(LEB), .ON_MAX(ON_MAX), .RS_SHORT(RS_SHORT), .RS_LONG(RS_LONG),
                   .OFF_MAX(OFF_MAX), .SSW(SSW), .VALLEY_W(VW)) u_dut (
        .clk(clk), .rst(rst), .zc_i(zc), .ring_low_i(ring_low), .fb_trip_i(fb),
        .ilim_trip_i(ilim), .short_trip_i(shrt), .valley_ref_i(valley),
        .gate_o(gate_o), .fault_o(fault_o));

    // run-length monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            cur_hi = 0; cur_lo = 0;
        end else if (gate_o) begin
            if (cur_lo != 0) begin last_lo = cur_lo; cur_lo = 0; end
            cur_hi = cur_hi + 1;
        end else begin
            if (cur_hi != 0) begin last_hi = cur_hi; cur_hi = 0; end
            cur_lo = cur_lo + 1;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        do begin @(negedge clk); #1; end while (!(gate_o && cur_hi == 1));
    endtask

    task automatic wait_fall();
        do begin @(negedge clk); #1; end while (!(!gate_o && cur_lo == 1));
    endtask

    task automatic next_cycle();
        @(posedge clk); #2;
    endtask

    task automatic trip_at(input bit use_ilim, input int k);
        wait_rise();
        repeat (k - 1) @(posedge clk);
        #2;
        if (use_ilim) ilim = 1; else fb = 1;
        wait_fall();
        next_cycle();
        ilim = 0; fb = 0;
    endtask

    task automatic valley_case(input int v_ref, input int npulses, input int exp, input string req);
        valley = VW'(v_ref);
        wait_fall();
        for (int i = 0; i < npulses; i++) begin
            next_cycle(); zc = 1;
            next_cycle(); zc = 0;
        end
        wait_rise();
        check_eq(req, last_lo, exp);
    endtask

    task automatic ring_case(input bit at_off, input bit later, input int exp, input string req);
        valley = '0;
        wait_rise();
        ring_low = at_off;
        wait_fall();
        next_cycle();
        ring_low = later;
        wait_rise();
        check_eq(req, last_lo, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int bad;
        // R1: reset state and long first window despite ring_low=0
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 gate in reset", gate_o, 0);
        check_eq("R1 fault in reset", fault_o, 0);
        @(posedge clk); #2; rst = 0;
        @(negedge clk); #1;
        check_eq("R1 gate after reset", gate_o, 0);
        wait_rise();
        check_eq("R1 first off uses RS_LONG", last_lo, RS_LONG);

        // R5: untripped on period
        wait_fall();
        check_eq("R5 max on", last_hi, ON_MAX);

        // R2/R3: feedback trip swept over the on period
        for (int k = 2; k <= ON_MAX; k++) begin
            trip_at(1'b0, k);
            check_eq($sformatf("R3 fb at k=%0d (R2 blank)", k), last_hi, (k > LEB + 1) ? k : LEB + 1);
        end
        // R2/R4: current limit swept
        for (int k = 2; k <= ON_MAX; k++) begin
            trip_at(1'b1, k);
            check_eq($sformatf("R4 ilim at k=%0d (R2 blank)", k), last_hi, ((k > LEB + 1) ? k : LEB + 1) - 1);
        end

        // R6: window choice sampled at turn-off and held
        ring_case(1'b0, 1'b0, RS_SHORT, "R6 short window");
        ring_case(1'b1, 1'b1, RS_LONG,  "R6 long window");
        ring_case(1'b0, 1'b1, RS_SHORT, "R6 hold short");
        ring_case(1'b1, 1'b0, RS_LONG,  "R6 hold long");

        // R7: valley sweep with pulses in off cycles 2,4,6,...
        ring_low = 0;
        wait_rise();
        for (int v = 0; v <= 8; v++)
            valley_case(v, v, (2*v + 3 > RS_SHORT && v > 0) ? 2*v + 3 : RS_SHORT,
                        $sformatf("R7 valley v=%0d", v));
        // R9: count never reached
        for (int v = 0; v <= 4; v++)
            valley_case(v + 1, v, OFF_MAX, $sformatf("R9 forced on v=%0d", v));

        // R8: count clears on turn-on; pulses while on do not count
        valley_case(2, 2, 7, "R8 setup");
        for (int i = 0; i < 3; i++) begin
            next_cycle(); zc = 1;
            next_cycle(); zc = 0;
        end
        wait_fall();
        wait_rise();
        check_eq("R8 on-time edges and stale count ignored", last_lo, OFF_MAX);

        // R10: short runs below SSW do nothing
        valley = '0;
        next_cycle(); shrt = 1;
        repeat (SSW - 2) next_cycle();
        next_cycle(); shrt = 0;
        repeat (3) next_cycle();
        shrt = 1;
        repeat (SSW - 2) next_cycle();
        next_cycle(); shrt = 0;
        next_cycle(); shrt = 1;
        repeat (SSW - 2) next_cycle();
        next_cycle(); shrt = 0;
        @(negedge clk);
        check_eq("R10 short runs ignored", fault_o, 0);
        repeat (4) next_cycle();
        // R10: full run latches
        shrt = 1;
        repeat (SSW - 1) next_cycle();
        @(negedge clk);
        check_eq("R10 no fault before SSW cycles", fault_o, 0);
        next_cycle(); shrt = 0;
        @(negedge clk);
        check_eq("R10 fault set", fault_o, 1);
        check_eq("R10 gate forced low", gate_o, 0);
        // R11: latched regardless of inputs
        bad = 0;
        ilim = 0; fb = 0; valley = '0; zc = 0;
        for (int i = 0; i < 2*OFF_MAX; i++) begin
            @(negedge clk);
            if (gate_o || !fault_o) bad++;
            if (i == 5) zc = 1;
            if (i == 7) zc = 0;
        end
        check_eq("R11 fault held, gate low", bad, 0);
        next_cycle(); rst = 1;
        next_cycle(); rst = 0;
        @(negedge clk);
        check_eq("R11 reset clears fault", fault_o, 0);
        check_eq("R11 gate low after reset", gate_o, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule